// File: doc/BRIEF.md
# Crosstalk-Avoiding Double-Error-Correcting Link Codec

This block protects data flits crossing a long on-chip link between network switches. On the sending side, each flit is turned into a Hamming codeword. An overall parity bit is added, and every codeword bit is driven on two neighbouring wires. Placing the two copies of a bit side by side means no wire ever switches against both of its neighbours at once, so the worst-case coupling on the link is limited. Together, the three layers give a code whose minimum distance is 7.

On the receiving side, the block rebuilds the flit from the wires and repairs any pattern of up to two wire errors. It also reports whether a repair took place. It raises a separate flag when the received pattern is known to be beyond its reach.

Both directions are qualified by a valid bit and registered once. Each therefore adds exactly one cycle, and each can take the place of an existing pipeline stage of the link. While valid is low, the registered outputs hold their last value.

Top module: `cadec_link`

## Requirements
- R1: The codeword has DATA_W+CHK_W positions, numbered from 1. Check bits sit at the power-of-two positions 1, 2, 4, 8, 16 and 32. Flit bits fill the remaining positions, flit bit 0 at the lowest free position and ascending from there. Check bit k is the even parity of all flit-carrying positions whose index has bit k set, so the XOR of the indices of all set positions is zero.
- R2: Codeword position i drives wires 2(i-1) and 2(i-1)+1 (wire 0 is the LSB). The top wire, 2(DATA_W+CHK_W), carries the XOR of all codeword bits.
- R3: tx_wires_valid is tx_valid delayed by one cycle, and tx_wires shows the encoding of the flit accepted in that earlier cycle. A cycle with tx_valid low leaves tx_wires unchanged.
- R4: A received word with no wire error yields the original flit, with rx_repaired=0 and rx_unrecoverable=0.
- R5: Any single wire in error, including the parity wire, yields the original flit with rx_repaired=1 and rx_unrecoverable=0.
- R6: Any two wires in error yield the original flit with rx_repaired=1 and rx_unrecoverable=0.
- R7: rx_flit_valid is rx_valid delayed by one cycle. A cycle with rx_valid low leaves rx_flit, rx_repaired and rx_unrecoverable unchanged.
- R8: rx_unrecoverable is 1 exactly when both of the following hold: the first copy together with the parity wire has even parity, and both copies have a nonzero syndrome. An example is two errors in the first copy plus one in the second. Whenever rx_unrecoverable is 1, rx_repaired is also 1.
- R9: While rst_n is low, and after release until the first valid input, tx_wires_valid and rx_flit_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Flit to encode is present |
| tx_flit | input | 32 | Flit to encode |
| tx_wires_valid | output | 1 | Encoded word is valid |
| tx_wires | output | 77 | Encoded word driven onto the link |
| rx_valid | input | 1 | Received word is present |
| rx_wires | input | 77 | Word received from the link |
| rx_flit_valid | output | 1 | Decoded flit is valid |
| rx_flit | output | 32 | Decoded flit |
| rx_repaired | output | 1 | At least one wire error was detected and handled |
| rx_unrecoverable | output | 1 | Error pattern lies beyond the correction capability |

## Verification
The bench builds the block with its default DATA_W of 32, which gives a 38-position codeword and a 77-wire link. At that size, every single-wire flip and every one of the 2926 two-wire flip pairs can be applied to several flits within the cycle budget. The correction claim is therefore covered exhaustively rather than by sampling. Hand-placed three-error patterns reach the uncorrectable flag. Randomly gated valid cycles exercise the hold behaviour of both registered paths.

// File: rtl/cadec_pkg.sv
package cadec_pkg;

  typedef enum logic {
    SEL_COPY1 = 1'b0,
    SEL_COPY2 = 1'b1
  } cadec_sel_e;

  // Smallest check-bit count whose codeword positions all get a unique syndrome.
  function automatic int chk_bits(input int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Flit bit index carried at a non-power-of-two codeword position.
  function automatic int data_slot(input int pos);
    int n;
    n = 0;
    for (int q = 1; q < pos; q++) begin
      if (!is_pow2(q)) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/cadec_hamm_enc.sv
module cadec_hamm_enc
  import cadec_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   cw
);

  // Flit bits that feed check bit k.
  function automatic logic [DATA_W-1:0] cover_mask(input int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int pos = 1; pos <= CW_W; pos++) begin
      if (!is_pow2(pos) && (((pos >> k) & 1) == 1)) m[data_slot(pos)] = 1'b1;
    end
    return m;
  endfunction

  for (genvar pos = 1; pos <= CW_W; pos++) begin : g_pos
    if (is_pow2(pos)) begin : g_chk
      localparam logic [DATA_W-1:0] MASK = cover_mask($clog2(pos));
      assign cw[pos-1] = ^(data & MASK);
    end else begin : g_dat
      assign cw[pos-1] = data[data_slot(pos)];
    end
  end

endmodule

// File: rtl/cadec_hamm_dec.sv
module cadec_hamm_dec
  import cadec_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int IDX_W  = $clog2(CW_W)
) (
  input  logic [CW_W-1:0]   cw,
  output logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] data
);

  // Codeword positions whose index has bit k set.
  function automatic logic [CW_W-1:0] pos_mask(input int k);
    logic [CW_W-1:0] m;
    m = '0;
    for (int pos = 1; pos <= CW_W; pos++) begin
      if (((pos >> k) & 1) == 1) m[pos-1] = 1'b1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    localparam logic [CW_W-1:0] MASK = pos_mask(k);
    assign syn[k] = ^(cw & MASK);
  end

  logic [CW_W-1:0]  fixed;
  logic [IDX_W-1:0] flip_idx;

  always_comb begin
    fixed    = cw;
    flip_idx = IDX_W'(syn - 1'b1);
    if ((syn != '0) && (int'(syn) <= CW_W)) fixed[flip_idx] = ~cw[flip_idx];
  end

  for (genvar pos = 1; pos <= CW_W; pos++) begin : g_ext
    if (!is_pow2(pos)) begin : g_dat
      assign data[data_slot(pos)] = fixed[pos-1];
    end
  end

endmodule

// File: rtl/cadec_enc.sv
module cadec_enc
  import cadec_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int WIRE_W = 2 * CW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [WIRE_W-1:0] out_wires
);

  logic [CW_W-1:0]   cw;
  logic [WIRE_W-1:0] spread;
  logic [WIRE_W-1:0] wires_nxt;
  logic              valid_nxt;

  cadec_hamm_enc #(.DATA_W(DATA_W)) u_hamm (
    .data (in_data),
    .cw   (cw)
  );

  for (genvar i = 0; i < CW_W; i++) begin : g_dup
    assign spread[2*i]   = cw[i];
    assign spread[2*i+1] = cw[i];
  end
  assign spread[WIRE_W-1] = ^cw;

  always_comb begin
    valid_nxt = in_valid;
    wires_nxt = out_wires;
    if (in_valid) wires_nxt = spread;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wires <= '0;
    end else begin
      out_valid <= valid_nxt;
      out_wires <= wires_nxt;
    end
  end

  // Independent syndrome over the first copy of the registered word.
  logic [CHK_W-1:0] c1_syn;
  always_comb begin
    c1_syn = '0;
    for (int pos = 1; pos <= CW_W; pos++) begin
      if (out_wires[2*(pos-1)]) c1_syn = c1_syn ^ CHK_W'(pos);
    end
  end

  AST_ENC_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c1_syn == '0)); // R1
  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_wires))); // R3
  always @(posedge clk) begin
    if (!rst_n) AST_ENC_RESET_IDLE: assert (!out_valid); // R9
  end

endmodule

// File: rtl/cadec_dec.sv
module cadec_dec
  import cadec_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int WIRE_W = 2 * CW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WIRE_W-1:0] in_wires,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fixed,
  output logic              out_fail
);

  logic [CW_W-1:0]   copy1, copy2;
  logic              par_wire;
  logic [CHK_W-1:0]  syn1, syn2;
  logic [DATA_W-1:0] data1, data2;

  for (genvar i = 0; i < CW_W; i++) begin : g_split
    assign copy1[i] = in_wires[2*i];
    assign copy2[i] = in_wires[2*i+1];
  end
  assign par_wire = in_wires[WIRE_W-1];

  cadec_hamm_dec #(.DATA_W(DATA_W)) u_dec1 (
    .cw   (copy1),
    .syn  (syn1),
    .data (data1)
  );

  cadec_hamm_dec #(.DATA_W(DATA_W)) u_dec2 (
    .cw   (copy2),
    .syn  (syn2),
    .data (data2)
  );

  // Even parity of copy 1 plus the parity wire means copy 1 holds 0 or 2
  // errors; a zero syndrome then rules out 2, otherwise copy 2 is clean.
  logic       par_ok;
  cadec_sel_e sel;
  logic       valid_nxt, fixed_nxt, fail_nxt;
  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    par_ok    = ~(^copy1 ^ par_wire);
    sel       = (par_ok && (syn1 == '0)) ? SEL_COPY1 : SEL_COPY2;
    valid_nxt = in_valid;
    data_nxt  = out_data;
    fixed_nxt = out_fixed;
    fail_nxt  = out_fail;
    if (in_valid) begin
      data_nxt  = (sel == SEL_COPY1) ? data1 : data2;
      fixed_nxt = !par_ok || (syn1 != '0) || (copy1 != copy2);
      fail_nxt  = par_ok && (syn1 != '0) && (syn2 != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_fixed <= 1'b0;
      out_fail  <= 1'b0;
    end else begin
      out_valid <= valid_nxt;
      out_data  <= data_nxt;
      out_fixed <= fixed_nxt;
      out_fail  <= fail_nxt;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_fixed) && $stable(out_fail))); // R7
  AST_DEC_FAIL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fail) |-> out_fixed); // R8
  AST_DEC_CLEAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (copy1 == copy2) && par_ok && (syn1 == '0)) |=> (!out_fixed && !out_fail)); // R4
  always @(posedge clk) begin
    if (!rst_n) AST_DEC_RESET_IDLE: assert (!out_valid); // R9
  end

endmodule

// File: rtl/cadec_link.sv
module cadec_link
  import cadec_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int CW_W   = DATA_W + CHK_W,
  localparam int WIRE_W = 2 * CW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_flit,
  output logic              tx_wires_valid,
  output logic [WIRE_W-1:0] tx_wires,
  input  logic              rx_valid,
  input  logic [WIRE_W-1:0] rx_wires,
  output logic              rx_flit_valid,
  output logic [DATA_W-1:0] rx_flit,
  output logic              rx_repaired,
  output logic              rx_unrecoverable
);

  cadec_enc #(.DATA_W(DATA_W)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_valid),
    .in_data   (tx_flit),
    .out_valid (tx_wires_valid),
    .out_wires (tx_wires)
  );

  cadec_dec #(.DATA_W(DATA_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_valid),
    .in_wires  (rx_wires),
    .out_valid (rx_flit_valid),
    .out_data  (rx_flit),
    .out_fixed (rx_repaired),
    .out_fail  (rx_unrecoverable)
  );

endmodule

// File: tb/cadec_link_tb.sv
`timescale 1ns/1ps
module cadec_link_tb;

  localparam int DW = 32;
  localparam int WW = 77;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tx_valid;
  logic [DW-1:0] tx_flit;
  logic          tx_wires_valid;
  logic [WW-1:0] tx_wires;
  logic          rx_valid;
  logic [WW-1:0] rx_wires;
  logic          rx_flit_valid;
  logic [DW-1:0] rx_flit;
  logic          rx_repaired;
  logic          rx_unrecoverable;

  always #10 clk = ~clk;

  cadec_link #(.DATA_W(DW)) u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .tx_valid         (tx_valid),
    .tx_flit          (tx_flit),
    .tx_wires_valid   (tx_wires_valid),
    .tx_wires         (tx_wires),
    .rx_valid         (rx_valid),
    .rx_wires         (rx_wires),
    .rx_flit_valid    (rx_flit_valid),
    .rx_flit          (rx_flit),
    .rx_repaired      (rx_repaired),
    .rx_unrecoverable (rx_unrecoverable)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Expected state of both registered paths.
  logic          exp_tv, exp_dv, exp_dc, exp_du;
  logic [WW-1:0] exp_tw;
  logic [DW-1:0] exp_df;
  bit            have_t = 0, have_d = 0;
  string         exp_tag = "R4";

  // Behavioural encoding: check bits are the bits of the XOR of set data positions.
  function automatic logic [WW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [37:0]   cw;
    logic [WW-1:0] w;
    int j, s;
    cw = '0; j = 0; s = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        cw[pos-1] = d[j];
        if (d[j]) s = s ^ pos;
        j++;
      end
    end
    for (int k = 0; k < 6; k++) cw[(1 << k) - 1] = s[k];
    for (int i = 0; i < 38; i++) begin
      w[2*i]   = cw[i];
      w[2*i+1] = cw[i];
    end
    w[76] = ^cw;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drive one cycle of both paths at a negedge, check one negedge later.
  task automatic step(input bit tv, input logic [DW-1:0] tf, input bit rv,
                      input logic [DW-1:0] rf, input logic [WW-1:0] msk, input bit unc);
    int nerr;
    tx_valid = tv;
    tx_flit  = tf;
    rx_valid = rv;
    rx_wires = ref_enc(rf) ^ msk;
    exp_tv   = tv;
    if (tv) begin exp_tw = ref_enc(tf); have_t = 1; end
    exp_dv   = rv;
    if (rv) begin
      nerr   = $countones(msk);
      exp_df = rf;
      exp_dc = (nerr != 0);
      exp_du = unc;
      have_d = 1;
      if (unc) exp_tag = "R8";
      else if (nerr == 0) exp_tag = "R4";
      else if (nerr == 1) exp_tag = "R5";
      else exp_tag = "R6";
    end
    @(negedge clk);
    chk(tx_wires_valid == exp_tv, "R3 tx_wires_valid", WW'(tx_wires_valid), WW'(exp_tv));
    if (have_t) chk(tx_wires == exp_tw, tv ? "R1 R2 tx_wires" : "R3 tx_wires hold", tx_wires, exp_tw);
    chk(rx_flit_valid == exp_dv, "R7 rx_flit_valid", WW'(rx_flit_valid), WW'(exp_dv));
    if (have_d) begin
      if (!exp_du)
        chk(rx_flit == exp_df, rv ? {exp_tag, " rx_flit"} : "R7 rx_flit hold", WW'(rx_flit), WW'(exp_df));
      chk(rx_repaired == exp_dc, rv ? {exp_tag, " rx_repaired"} : "R7 rx_repaired hold",
          WW'(rx_repaired), WW'(exp_dc));
      chk(rx_unrecoverable == exp_du, rv ? {exp_tag, " rx_unrecoverable"} : "R7 rx_unrecoverable hold",
          WW'(rx_unrecoverable), WW'(exp_du));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [DW-1:0] flits [3];
    logic [WW-1:0] m;
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_flit  = '0;
    rx_valid = 1'b0;
    rx_wires = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!tx_wires_valid && !rx_flit_valid, "R9 valids in reset",
          WW'({tx_wires_valid, rx_flit_valid}), '0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_wires_valid && !rx_flit_valid, "R9 valids after release",
        WW'({tx_wires_valid, rx_flit_valid}), '0);

    // Clean words, several patterns (R1 R2 R4).
    step(1, 32'h0000_0000, 1, 32'h0000_0000, '0, 0);
    step(1, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, '0, 0);
    step(1, 32'h0000_0001, 1, 32'h8000_0000, '0, 0);
    for (int t = 0; t < 20; t++) step(1, $urandom, 1, $urandom, '0, 0);

    // Idle cycles: outputs must hold (R3 R7).
    step(0, $urandom, 0, $urandom, '0, 0);
    step(0, $urandom, 0, $urandom, '0, 0);

    // Every single wire error, including the parity wire (R5).
    for (int f = 0; f < 2; f++) begin
      logic [DW-1:0] d;
      d = $urandom;
      for (int a = 0; a < WW; a++) begin
        m = '0; m[a] = 1'b1;
        step(1, $urandom, 1, d, m, 0);
      end
    end

    // Every pair of wire errors on three flits (R6).
    flits[0] = 32'h0000_0000;
    flits[1] = 32'hFFFF_FFFF;
    flits[2] = $urandom;
    for (int f = 0; f < 3; f++) begin
      for (int a = 0; a < WW; a++) begin
        for (int b = a + 1; b < WW; b++) begin
          m = '0; m[a] = 1'b1; m[b] = 1'b1;
          step(1, $urandom, 1, flits[f], m, 0);
        end
      end
    end

    // Two errors in copy 1 plus one in copy 2: flagged as unrecoverable (R8).
    for (int t = 0; t < 16; t++) begin
      int p1, p2, q;
      p1 = $urandom_range(38, 1);
      p2 = $urandom_range(38, 1);
      if (p2 == p1) p2 = (p1 % 38) + 1;
      q  = $urandom_range(38, 1);
      m = '0;
      m[2*(p1-1)]   = 1'b1;
      m[2*(p2-1)]   = 1'b1;
      m[2*(q-1)+1]  = 1'b1;
      step(1, $urandom, 1, $urandom, m, 1);
    end
    // A clean word afterwards clears the flags (R4).
    step(1, $urandom, 1, $urandom, '0, 0);

    // Randomly gated valids with up to two errors (R3 R7).
    for (int t = 0; t < 300; t++) begin
      int ne;
      bit tv, rv;
      tv = $urandom_range(1, 0);
      rv = $urandom_range(1, 0);
      ne = $urandom_range(2, 0);
      m = '0;
      if (ne >= 1) m[$urandom_range(WW-1, 0)] = 1'b1;
      if (ne == 2) begin
        int a;
        a = $urandom_range(WW-1, 0);
        while (m[a]) a = $urandom_range(WW-1, 0);
        m[a] = 1'b1;
      end
      step(tv, $urandom, rv, $urandom, m, 0);
    end

    summary();
  end

endmodule